// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Wake Scheduler

This block keeps every row of a 256-row asynchronous DRAM refreshed and brings the device up after power-on. Out of reset it waits a programmable pause, then runs a burst of wake-up refresh cycles. Only after that burst does it report that the memory is ready. From then on an interval timer raises one refresh request per period. Each request is served either as a CAS-before-RAS cycle, where the DRAM's own counter picks the row, or as a RAS-only cycle, where the block drives the row from its own 8-bit counter. A static mode input chooses between the two.

The block does not own the DRAM pins. It asks the access sequencer for them with `bus_req` and waits for `bus_gnt`. While it holds the grant it drives the row strobe, both column strobes, the write enable and the address. If the grant is late, the requests that arrive meanwhile are counted and then run back to back in one tenure. If the backlog would pass its limit, the refresh interval counts as exceeded: the block drops its ready flag and runs the whole wake-up burst again. The data pins are never touched. A `host_ok` output tells the access sequencer when host traffic may go ahead. It is low before the memory is ready and whenever a refresh is pending or running, which gives refresh priority over host traffic.

Top module: `rfs_sched`

## Requirements
- R1: While reset is asserted and right after it, `ras_n`, `casl_n`, `cash_n` and `we_n` are 1, and `bus_req`, `init_done` and `host_ok` are 0.
- R2: `bus_req` stays 0 for the first PAUSE_CYC clock edges after reset release. It first rises after edge PAUSE_CYC+1.
- R3: After the pause exactly WAKE_N refresh cycles (falling edges of `ras_n`) occur before `init_done` rises. `bus_req` is 0 when it rises.
- R4: With `ras_only_mode`=0 (CAS-before-RAS), `casl_n` and `cash_n` are 0 for SETUP_CYC cycles before `ras_n` falls. They stay 0 while `ras_n` is 0 and rise together with it. `we_n` is 1 throughout.
- R5: With `ras_only_mode`=1, `casl_n` and `cash_n` stay 1. `addr` carries the row count during the SETUP_CYC cycles before `ras_n` falls and is stable while `ras_n` is 0. It is 0 outside those cycles.
- R6: `ras_n` is low for exactly RAS_CYC cycles per refresh. Before the next fall it is high for at least PRE_CYC+SETUP_CYC cycles.
- R7: In RAS-only mode the row count starts at 0 after reset and steps by one after every refresh cycle, wake-up cycles included. It wraps from 255 to 0.
- R8: After the ready flag rises, one refresh request is raised every INTERVAL_CYC cycles. Requests that arrive while the grant is withheld are kept, up to PEND_MAX. Once granted they run back to back without `bus_req` falling between them.
- R9: A request that arrives while PEND_MAX are already pending and none is being started drops `init_done`. WAKE_N refresh cycles are then run before `init_done` returns to 1.
- R10: `host_ok` is 1 only when `init_done` is 1, no request is pending and the block is not requesting or holding the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all timing counts are in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_only_mode | input | 1 | Static mode: 1 = RAS-only refresh with row count on `addr`, 0 = CAS-before-RAS |
| bus_gnt | input | 1 | Access sequencer hands the DRAM pins to this block; held while `bus_req` is 1 |
| bus_req | output | 1 | Request for the DRAM pins, held across back-to-back cycles |
| ras_n | output | 1 | Row strobe, active low |
| casl_n | output | 1 | Lower-byte column strobe, active low |
| cash_n | output | 1 | Upper-byte column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| addr | output | ROW_W | Row address in RAS-only mode, else 0 |
| init_done | output | 1 | Memory ready: pause and wake-up burst complete |
| host_ok | output | 1 | Host traffic may be granted |

## Verification
The hardest state to reach is a backlog overflow. The grant has to stay withheld across several whole refresh periods, starting exactly on the tick that raised the first request. Only then do the counts of pending requests come out deterministic. The bench stalls its grant model when the bus is idle and waits for the first request to appear. It then holds off for a computed number of periods: two more ticks to test back-to-back service, four more to force the re-wake. A behavioural queue model predicts every pin on every cycle along the way. A long RAS-only run then carries the row count through its wrap from 255 to 0.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_REQ,
    SQ_SETUP,
    SQ_ACT,
    SQ_PRE
  } seq_state_t;

  // next backlog value: saturating add, then consume one
  function automatic int unsigned backlog_step(int unsigned cur, logic add,
                                               logic take, int unsigned cap);
    int unsigned r;
    r = cur;
    if (add && (r < cap)) r = r + 1;
    if (take && (r > 0)) r = r - 1;
    return r;
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b,
                                       int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/rfs_timer.sv
module rfs_timer #(
  parameter int unsigned LIMIT = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned TW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [TW-1:0] cnt_q;

  assign tick = en && (cnt_q == TW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else if (en)     cnt_q <= cnt_q + TW'(1);
  end

  // R8
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/rfs_backlog.sv
module rfs_backlog import rfs_pkg::*; #(
  parameter int unsigned WAKE_N   = 8,
  parameter int unsigned PEND_MAX = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wake_req,
  input  logic add,
  input  logic take,
  input  logic seq_idle,
  output logic has_work,
  output logic waking
);
  localparam int unsigned PTOP = (WAKE_N > PEND_MAX) ? WAKE_N : PEND_MAX;
  localparam int unsigned PW   = $clog2(PTOP + 1);

  logic [PW-1:0] pend_q;
  logic          waking_q;
  logic          ovf;
  logic          load;

  // interval exceeded: a new request finds the backlog full
  assign ovf  = add && !take && (pend_q >= PW'(PEND_MAX)) && !waking_q;
  assign load = wake_req || ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      waking_q <= 1'b0;
    end else begin
      if (load) pend_q <= PW'(WAKE_N);
      else      pend_q <= PW'(backlog_step(32'(pend_q), add, take, PEND_MAX));
      if (load)                         waking_q <= 1'b1;
      else if (seq_idle && pend_q == '0) waking_q <= 1'b0;
    end
  end

  assign has_work = (pend_q != '0);
  assign waking   = waking_q;

  // R8
  backlog_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !waking_q |-> (pend_q <= PW'(PEND_MAX)));

  // R9
  rewake_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (waking_q && pend_q == PW'(WAKE_N)));

endmodule

// File: rtl/rfs_seq.sv
module rfs_seq import rfs_pkg::*; #(
  parameter int unsigned ROW_W     = 8,
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned RAS_CYC   = 2,
  parameter int unsigned PRE_CYC   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_only,
  input  logic             work,
  input  logic             bus_gnt,
  output logic             take,
  output logic             idle,
  output logic             bus_req,
  output logic             ras_n,
  output logic             cas_n,
  output logic [ROW_W-1:0] addr
);
  localparam int unsigned CMAX = max3(SETUP_CYC, RAS_CYC, PRE_CYC + SETUP_CYC);
  localparam int unsigned CW   = $clog2(CMAX + 1) + 1;

  seq_state_t       st_q;
  logic [CW-1:0]    cnt_q;
  logic [ROW_W-1:0] row_q;
  logic             phase_done;
  logic             strobe;
  logic             ras_end;
  logic             cyc_end;

  assign phase_done = (cnt_q == '0);
  assign strobe     = (st_q == SQ_SETUP) || (st_q == SQ_ACT);
  assign ras_end    = (st_q == SQ_ACT) && phase_done;
  assign cyc_end    = (st_q == SQ_PRE) && phase_done;
  assign take       = ((st_q == SQ_REQ) && bus_gnt) || (cyc_end && work);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        SQ_IDLE: if (work) st_q <= SQ_REQ;
        SQ_REQ: if (bus_gnt) begin
          st_q  <= SQ_SETUP;
          cnt_q <= CW'(SETUP_CYC - 1);
        end
        SQ_SETUP: if (phase_done) begin
          st_q  <= SQ_ACT;
          cnt_q <= CW'(RAS_CYC - 1);
        end else cnt_q <= cnt_q - CW'(1);
        SQ_ACT: if (phase_done) begin
          st_q  <= SQ_PRE;
          cnt_q <= CW'(PRE_CYC - 1);
        end else cnt_q <= cnt_q - CW'(1);
        SQ_PRE: if (phase_done) begin
          if (work) begin
            st_q  <= SQ_SETUP;
            cnt_q <= CW'(SETUP_CYC - 1);
          end else st_q <= SQ_IDLE;
        end else cnt_q <= cnt_q - CW'(1);
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 row_q <= '0;
    else if (ras_end && ras_only) row_q <= row_q + ROW_W'(1);
  end

  assign idle    = (st_q == SQ_IDLE);
  assign bus_req = (st_q != SQ_IDLE);
  assign ras_n   = (st_q != SQ_ACT);
  assign cas_n   = !(strobe && !ras_only);
  assign addr    = (strobe && ras_only) ? row_q : '0;

  // assertion support: run lengths of the row strobe
  logic [CW-1:0] low_len_q;
  logic [CW-1:0] high_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_len_q  <= '0;
      high_len_q <= CW'(CMAX);
    end else if (ras_n) begin
      low_len_q  <= '0;
      if (high_len_q != CW'(CMAX)) high_len_q <= high_len_q + CW'(1);
    end else begin
      high_len_q <= '0;
      low_len_q  <= low_len_q + CW'(1);
    end
  end

  // R6
  ras_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (low_len_q == CW'(RAS_CYC)));

  // R6
  precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (high_len_q >= CW'(PRE_CYC + SETUP_CYC)));

  // R4
  cbr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !ras_only) |-> (!cas_n && $past(!cas_n)));

  // R5
  rasonly_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && ras_only) |-> (cas_n && $stable(addr)));

  // R7
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ras_n) && ras_only) |-> (row_q == $past(row_q) + ROW_W'(1)));

endmodule

// File: rtl/rfs_sched.sv
module rfs_sched import rfs_pkg::*; #(
  parameter int unsigned PAUSE_CYC    = 10000,
  parameter int unsigned INTERVAL_CYC = 780,
  parameter int unsigned WAKE_N       = 8,
  parameter int unsigned PEND_MAX     = 4,
  parameter int unsigned SETUP_CYC    = 1,
  parameter int unsigned RAS_CYC      = 2,
  parameter int unsigned PRE_CYC      = 1,
  parameter int unsigned ROW_W        = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_only_mode,
  input  logic             bus_gnt,
  output logic             bus_req,
  output logic             ras_n,
  output logic             casl_n,
  output logic             cash_n,
  output logic             we_n,
  output logic [ROW_W-1:0] addr,
  output logic             init_done,
  output logic             host_ok
);
  logic pause_done_q;
  logic pause_tick;
  logic ref_tick;
  logic take;
  logic seq_idle;
  logic has_work;
  logic waking;
  logic cas_n;

  rfs_timer #(.LIMIT(PAUSE_CYC)) u_pause (
    .clk(clk), .rst_n(rst_n), .en(!pause_done_q), .tick(pause_tick));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pause_done_q <= 1'b0;
    else if (pause_tick) pause_done_q <= 1'b1;
  end

  rfs_timer #(.LIMIT(INTERVAL_CYC)) u_interval (
    .clk(clk), .rst_n(rst_n), .en(pause_done_q), .tick(ref_tick));

  rfs_backlog #(.WAKE_N(WAKE_N), .PEND_MAX(PEND_MAX)) u_backlog (
    .clk(clk), .rst_n(rst_n), .wake_req(pause_tick), .add(ref_tick),
    .take(take), .seq_idle(seq_idle), .has_work(has_work), .waking(waking));

  rfs_seq #(.ROW_W(ROW_W), .SETUP_CYC(SETUP_CYC), .RAS_CYC(RAS_CYC),
            .PRE_CYC(PRE_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .ras_only(ras_only_mode), .work(has_work),
    .bus_gnt(bus_gnt), .take(take), .idle(seq_idle), .bus_req(bus_req),
    .ras_n(ras_n), .cas_n(cas_n), .addr(addr));

  assign casl_n    = cas_n;
  assign cash_n    = cas_n;
  assign we_n      = 1'b1;
  assign init_done = pause_done_q && !waking;
  assign host_ok   = init_done && seq_idle && !has_work;

  // R2
  pause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pause_done_q |-> !bus_req);

  // R3
  wake_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> !bus_req);

  // R10
  host_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ok |-> (init_done && !bus_req));

endmodule

// File: tb/test_rfs_sched.sv
module test_rfs_sched;
  localparam int PAUSE = 50;
  localparam int INTV  = 60;
  localparam int WAKE  = 8;
  localparam int PMAX  = 4;
  localparam int SCYC  = 1;
  localparam int ACYC  = 2;
  localparam int PCYC  = 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode = 1'b0;
  logic       gnt = 1'b0;
  logic       hold_off = 1'b0;
  logic       bus_req, ras_n, casl_n, cash_n, we_n, init_done, host_ok;
  logic [7:0] addr;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  rfs_sched #(.PAUSE_CYC(PAUSE), .INTERVAL_CYC(INTV), .WAKE_N(WAKE),
              .PEND_MAX(PMAX), .SETUP_CYC(SCYC), .RAS_CYC(ACYC),
              .PRE_CYC(PCYC), .ROW_W(8)) i_rfs_sched (
    .clk(clk), .rst_n(rst_n), .ras_only_mode(mode), .bus_gnt(gnt),
    .bus_req(bus_req), .ras_n(ras_n), .casl_n(casl_n), .cash_n(cash_n),
    .we_n(we_n), .addr(addr), .init_done(init_done), .host_ok(host_ok));

  task automatic chk(string tag, string what, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s got %0d expected %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // wave codes: 1 setup, 2 row strobe low, 3 last strobe-low cycle, 4 precharge
  int  m_wave[$];
  int  m_ptmr, m_itmr, m_pend, m_row;
  bit  m_pdone, m_wak, m_req, m_ok;
  bit  t_ptick, t_itick, t_last, t_idle, t_take, t_ovf, t_load, t_clr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_wave.delete();
      m_ptmr = 0; m_itmr = 0; m_pend = 0; m_row = 0;
      m_pdone = 0; m_wak = 0; m_req = 0; m_ok = 1;
    end else begin
      t_ptick = !m_pdone && (m_ptmr == PAUSE - 1);
      t_itick = m_pdone && (m_itmr == INTV - 1);
      t_last  = (m_wave.size() == 1);
      t_idle  = !m_req && (m_wave.size() == 0);
      t_take  = (m_req && gnt) || (t_last && m_pend > 0);
      t_ovf   = t_itick && !t_take && (m_pend >= PMAX) && !m_wak;
      t_load  = t_ptick || t_ovf;
      t_clr   = t_idle && (m_pend == 0);
      if (m_wave.size() > 0) begin
        if (m_wave[0] == 3 && mode) m_row = (m_row + 1) % 256;
        void'(m_wave.pop_front());
      end
      if (t_take) begin
        for (int i = 0; i < SCYC; i++) m_wave.push_back(1);
        for (int i = 0; i < ACYC - 1; i++) m_wave.push_back(2);
        m_wave.push_back(3);
        for (int i = 0; i < PCYC; i++) m_wave.push_back(4);
        m_req = 0;
      end else if (t_idle && m_pend > 0) m_req = 1;
      if (t_load) m_pend = WAKE;
      else begin
        if (t_itick && m_pend < PMAX) m_pend++;
        if (t_take) m_pend--;
      end
      if (t_load) m_wak = 1;
      else if (t_clr) m_wak = 0;
      if (!m_pdone) m_ptmr = t_ptick ? 0 : m_ptmr + 1;
      else m_itmr = t_itick ? 0 : m_itmr + 1;
      if (t_ptick) m_pdone = 1;
    end
  end

  // per-cycle comparison against the model
  initial begin
    int fr;
    bit stb, e_init;
    forever begin
      @(negedge clk);
      if (rst_n && m_ok) begin
        fr  = (m_wave.size() > 0) ? m_wave[0] : 0;
        stb = (fr >= 1 && fr <= 3);
        e_init = m_pdone && !m_wak;
        chk("R6", "ras_n", int'(ras_n), (fr == 2 || fr == 3) ? 0 : 1);
        chk(mode ? "R5" : "R4", "casl_n", int'(casl_n), (stb && !mode) ? 0 : 1);
        chk(mode ? "R5" : "R4", "cash_n", int'(cash_n), (stb && !mode) ? 0 : 1);
        chk("R4", "we_n", int'(we_n), 1);
        chk("R7", "addr", int'(addr), (stb && mode) ? m_row : 0);
        chk(m_pdone ? "R8" : "R2", "bus_req", int'(bus_req),
            (m_req || m_wave.size() > 0) ? 1 : 0);
        chk("R3", "init_done", int'(init_done), e_init ? 1 : 0);
        chk("R10", "host_ok", int'(host_ok),
            (e_init && !m_req && m_wave.size() == 0 && m_pend == 0) ? 1 : 0);
      end
    end
  end

  // grant model: grants a pending request unless held off, keeps it while requested
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n || !bus_req) gnt = 1'b0;
      else if (!hold_off)     gnt = 1'b1;
    end
  end

  // ---------------- directed scenario helpers ----------------
  bit p_ras = 1, p_cas = 1, fell = 0, rose = 0;
  int low_run = 0, edges = 0, exp_row = 0, row_falls = 0;

  always @(posedge clk) if (!rst_n) edges = 0; else edges++;

  task automatic step();
    @(negedge clk);
    fell = p_ras && !ras_n;
    rose = !p_ras && ras_n;
    if (!ras_n) low_run++;
    if (rose) begin
      chk("R6", "strobe-low run length", low_run, ACYC);
      low_run = 0;
    end
    if (fell && !mode) begin
      chk("R4", "column strobes low at row fall", int'(casl_n) + int'(cash_n), 0);
      chk("R4", "column strobe low before row fall", int'(p_cas), 0);
    end
    if (fell && mode) begin
      chk("R5", "column strobes high in row-only cycle", int'(casl_n & cash_n), 1);
      chk("R7", "row address at strobe fall", int'(addr), exp_row % 256);
      if (row_falls == 256) chk("R7", "row wrap to zero", int'(addr), 0);
      exp_row++;
      row_falls++;
    end
    p_ras = ras_n;
    p_cas = casl_n;
  endtask

  task automatic do_reset(bit m);
    rst_n = 1'b0;
    mode = m;
    hold_off = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "ras_n in reset", int'(ras_n), 1);
    chk("R1", "cas in reset", int'(casl_n & cash_n), 1);
    chk("R1", "we_n in reset", int'(we_n), 1);
    chk("R1", "bus_req in reset", int'(bus_req), 0);
    chk("R1", "init_done in reset", int'(init_done), 0);
    chk("R1", "host_ok in reset", int'(host_ok), 0);
    p_ras = 1; p_cas = 1; low_run = 0; exp_row = 0; row_falls = 0;
    rst_n = 1'b1;
  endtask

  task automatic wait_idle_ready();
    while (!(init_done && !bus_req)) step();
  endtask

  task automatic stall_from_tick(int extra);
    wait_idle_ready();
    hold_off = 1'b1;
    while (!bus_req) step();
    repeat (extra) step();
  endtask

  initial begin
    int falls;
    // ---- CAS-before-RAS mode ----
    do_reset(1'b0);
    step();
    chk("R1", "bus_req just after reset", int'(bus_req), 0);
    chk("R1", "init_done just after reset", int'(init_done), 0);
    while (!bus_req) step();
    chk("R2", "edges before first request", edges, PAUSE + 1);
    falls = 0;
    while (!init_done) begin
      step();
      if (fell) falls++;
    end
    chk("R3", "wake-up cycle count", falls, WAKE);
    chk("R3", "bus idle when ready", int'(bus_req), 0);
    chk("R10", "host allowed when idle and ready", int'(host_ok), 1);
    // normal periodic service
    falls = 0;
    repeat (3 * INTV) begin
      step();
      if (fell) falls++;
    end
    chk("R8", "one refresh per interval", falls, 3);
    // grant withheld for three requests
    stall_from_tick(2 * INTV + 10);
    chk("R10", "host blocked while refresh pending", int'(host_ok), 0);
    hold_off = 1'b0;
    falls = 0;
    while (bus_req) begin
      step();
      if (fell) falls++;
    end
    chk("R8", "back-to-back queued refreshes", falls, 3);
    // grant withheld past the backlog limit
    stall_from_tick(4 * INTV + 10);
    chk("R9", "ready flag dropped on overflow", int'(init_done), 0);
    hold_off = 1'b0;
    falls = 0;
    while (!init_done) begin
      step();
      if (fell) falls++;
    end
    chk("R9", "wake-up burst rerun", falls, WAKE);

    // ---- RAS-only mode ----
    do_reset(1'b1);
    while (row_falls < 258) step();
    chk("R7", "rows issued", row_falls, 258);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog run did not complete got 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule